// File: doc/BRIEF.md
# Two-Wire Register Slave with Write-Enable Latch

This block is the serial front end of a clock/calendar register file. It follows a two-wire (I2C-style) bus by oversampling SCL and SDA on the system clock. It detects start and stop conditions and matches a 7-bit device address. It then takes a one-byte word address and carries out byte writes, page writes, current-address reads and random reads on a 256-byte store. The store is a register array written so that a block RAM can be inferred. The slave pulls SDA low through an open-drain enable output. It does this to acknowledge a byte and to send read data.

The address space has four 64-byte pages. Pages 0 and 1 model non-volatile memory. Page 2 is write-protected. Page 3 holds the control registers, and its last byte (0xFF) holds a volatile write-enable latch. A write that lands in the non-volatile pages starts an internal busy period when the stop condition ends the transfer. While that period runs, the slave does not acknowledge its address, so a master can poll until it gets an acknowledge.

Top module: `twowire_reg_slave`

## Requirements
- R1: A start condition (SDA falls while SCL is high) restarts the slave at any point. A stop condition (SDA rises while SCL is high) returns it to idle. The first byte after a start is the device address, with bits 7:1 = DEV_ADDR (default 7'h50) and bit 0 = 1 for read, 0 for write.
- R2: In a write, the byte after the device address is the word address. Each data byte after it is stored at the current pointer. The slave acknowledges every byte by driving SDA low during the ninth clock.
- R3: During a write, the pointer advances only within its 64-byte page. Bits 5:0 wrap from 63 to 0 and bits 7:6 stay fixed.
- R4: A read with no word address (current-address read) starts at the pointer left by the last access. The pointer advances by one after each byte sent and wraps over the whole 256-byte space. Data goes out MSB first.
- R5: A random read is a write transfer that carries only a word address, then a repeated start and a device address with bit 0 = 1. It returns the bytes from that word address onward. The master ends a read by not acknowledging the last byte.
- R6: The write-enable latch is bit 1 of address 0xFF. A write to 0xFF sets or clears it and is always accepted. A read of 0xFF returns 8'h02 when the latch is set and 8'h00 when it is clear. While the latch is clear, writes to 0xC0–0xFE are acknowledged but dropped. Control-page writes never start a busy period.
- R7: Writes to the protected page 0x80–0xBF are acknowledged, leave the stored byte unchanged and start no busy period.
- R8: A stop that ends a write which stored at least one byte in 0x00–0x7F starts a busy period of BUSY_CYC clocks. During this period the device address is not acknowledged, for reads as well as writes.
- R9: After a device address that does not match, the slave gives no acknowledge and leaves SDA released through the ninth clock. It then ignores the bus until the next start condition.
- R10: The SDA drive enable changes only while SCL is low.
- R11: After reset the slave releases SDA, the latch is clear and the slave is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must be many times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus) |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |

## Verification
The bound checker checks on every clock that the drive enable only moves while the synchronized SCL is low. It also checks that no address acknowledge appears while the busy timer runs, and that the store never writes the protected page or a control register with the latch clear. Two further checks cover the latch, which changes only on a write to 0xFF, and the page bits of the write pointer, which hold across a data byte. Only the bench scenarios can show that data ends up where the address rules say. This includes in-page wrap, a current-address read continuing from a random read, a rejected device address swallowing the rest of its transfer, and the busy period ending so that polling is acknowledged again.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WADR,
    PH_WDAT,
    PH_RDAT,
    PH_SKIP
  } tws_phase_e;
endpackage

// File: rtl/tws_line_sense.sv
module tws_line_sense #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic rise_p,
  output logic fall_p,
  output logic start_p,
  output logic stop_p
);
  logic [SYNC-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC-2:0], sda_i};
      scl_d  <= scl_sr[SYNC-1];
      sda_d  <= sda_sr[SYNC-1];
    end
  end

  assign scl_lvl = scl_sr[SYNC-1];
  assign sda_lvl = sda_sr[SYNC-1];
  assign rise_p  = scl_lvl & ~scl_d;
  assign fall_p  = ~scl_lvl & scl_d;
  assign start_p = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_p  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/tws_busy.sv
module tws_busy #(
  parameter int CYC = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (kick)       cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/tws_store.sv
module tws_store #(
  parameter int AW        = 8,
  parameter int PAGE_W    = 6,
  parameter int PROT_PAGE = 2,
  parameter int WEL_BIT   = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          mem_we,
  output logic          nv_done,
  output logic          wel
);
  localparam int DEPTH = 2 ** AW;
  localparam int PG_W  = AW - PAGE_W;
  localparam logic [PG_W-1:0] PROT_PG  = PG_W'(PROT_PAGE);
  localparam logic [PG_W-1:0] CTRL_PG  = '1;
  localparam logic [AW-1:0]   LATCH_AD = '1;
  localparam logic [7:0]      WEL_MASK = 8'(1) << WEL_BIT;

  logic [7:0] mem [DEPTH];
  logic [7:0] rd_q;
  logic       sel_latch;
  logic       is_latch, is_ctrl, is_prot;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  assign is_latch = (wr_addr == LATCH_AD);
  assign is_ctrl  = (wr_addr[AW-1:PAGE_W] == CTRL_PG) && !is_latch;
  assign is_prot  = (wr_addr[AW-1:PAGE_W] == PROT_PG);
  assign mem_we   = wr_req && !is_latch && !is_prot && (!is_ctrl || wel);
  assign nv_done  = mem_we && !is_ctrl;

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel       <= 1'b0;
      sel_latch <= 1'b0;
    end else begin
      if (wr_req && is_latch) wel <= wr_data[WEL_BIT];
      sel_latch <= (rd_addr == LATCH_AD);
    end
  end

  assign rd_data = sel_latch ? (wel ? WEL_MASK : 8'h00) : rd_q;
endmodule

// File: rtl/tws_link.sv
module tws_link
  import tws_pkg::*;
#(
  parameter int         AW       = 8,
  parameter int         PAGE_W   = 6,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic          rise_p,
  input  logic          fall_p,
  input  logic          sda_lvl,
  input  logic          busy,
  input  logic          nv_done,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] ptr,
  output tws_phase_e    phase,
  output logic          busy_kick
);
  logic [7:0] sh;
  logic [3:0] bitcnt;
  logic       ack_slot;
  logic       mnack;
  logic       wrote_nv;

  assign wr_req    = fall_p && (phase == PH_WDAT) && !ack_slot && (bitcnt == 4'd8);
  assign wr_addr   = ptr;
  assign wr_data   = sh;
  assign busy_kick = stop_p && wrote_nv;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      sh       <= '0;
      bitcnt   <= '0;
      ack_slot <= 1'b0;
      mnack    <= 1'b0;
      sda_oe   <= 1'b0;
      ptr      <= '0;
      wrote_nv <= 1'b0;
    end else begin
      if (nv_done) wrote_nv <= 1'b1;
      if (start_p) begin
        phase    <= PH_DEV;
        bitcnt   <= '0;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_p) begin
        phase    <= PH_IDLE;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
        wrote_nv <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (rise_p) begin
          if (ack_slot) begin
            mnack <= sda_lvl;
          end else begin
            bitcnt <= bitcnt + 4'd1;
            if (phase != PH_RDAT) sh <= {sh[6:0], sda_lvl};
          end
        end else if (fall_p) begin
          if (ack_slot) begin
            ack_slot <= 1'b0;
            bitcnt   <= '0;
            sda_oe   <= 1'b0;
            if (phase == PH_SKIP) begin
              phase <= PH_IDLE;
            end else if (phase == PH_RDAT) begin
              if (mnack) begin
                phase <= PH_IDLE;
              end else begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                ptr    <= ptr + 1'b1;
              end
            end
          end else if (bitcnt == 4'd8) begin
            ack_slot <= 1'b1;
            case (phase)
              PH_DEV: begin
                if (sh[7:1] == DEV_ADDR && !busy) begin
                  sda_oe <= 1'b1;
                  mnack  <= 1'b0;
                  phase  <= sh[0] ? PH_RDAT : PH_WADR;
                end else begin
                  sda_oe <= 1'b0;
                  phase  <= PH_SKIP;
                end
              end
              PH_WADR: begin
                ptr    <= sh[AW-1:0];
                sda_oe <= 1'b1;
                phase  <= PH_WDAT;
              end
              PH_WDAT: begin
                sda_oe <= 1'b1;
                ptr    <= {ptr[AW-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (phase == PH_RDAT) begin
            sh     <= {sh[6:0], 1'b0};
            sda_oe <= ~sh[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/twowire_reg_slave.sv
module twowire_reg_slave
  import tws_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         AW        = 8,
  parameter int         PAGE_W    = 6,
  parameter int         PROT_PAGE = 2,
  parameter int         WEL_BIT   = 1,
  parameter int         BUSY_CYC  = 2000,
  parameter int         SYNC      = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic          scl_lvl, sda_lvl, rise_p, fall_p, start_p, stop_p;
  logic          busy, busy_kick;
  logic          wr_req, mem_we, nv_done, wel;
  logic [AW-1:0] wr_addr, ptr;
  logic [7:0]    wr_data, rd_data;
  tws_phase_e    phase;

  tws_line_sense #(.SYNC(SYNC)) sense_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .rise_p(rise_p), .fall_p(fall_p),
    .start_p(start_p), .stop_p(stop_p)
  );

  tws_link #(.AW(AW), .PAGE_W(PAGE_W), .DEV_ADDR(DEV_ADDR)) link_i (
    .clk(clk), .rst(rst), .start_p(start_p), .stop_p(stop_p),
    .rise_p(rise_p), .fall_p(fall_p), .sda_lvl(sda_lvl), .busy(busy),
    .nv_done(nv_done), .rd_data(rd_data), .sda_oe(sda_oe_o),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .ptr(ptr),
    .phase(phase), .busy_kick(busy_kick)
  );

  tws_store #(.AW(AW), .PAGE_W(PAGE_W), .PROT_PAGE(PROT_PAGE), .WEL_BIT(WEL_BIT)) store_i (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data), .mem_we(mem_we), .nv_done(nv_done), .wel(wel)
  );

  tws_busy #(.CYC(BUSY_CYC)) busy_i (
    .clk(clk), .rst(rst), .kick(busy_kick), .busy(busy)
  );
endmodule

// File: rtl/tws_checker.sv
module tws_checker
  import tws_pkg::*;
#(
  parameter int AW        = 8,
  parameter int PAGE_W    = 6,
  parameter int PROT_PAGE = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          sda_oe,
  input logic          scl_lvl,
  input logic          busy,
  input tws_phase_e    phase,
  input logic          wr_req,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] ptr,
  input logic          wel,
  input logic          mem_we
);
  localparam int PG_W = AW - PAGE_W;
  localparam logic [PG_W-1:0] PROT_PG  = PG_W'(PROT_PAGE);
  localparam logic [PG_W-1:0] CTRL_PG  = '1;
  localparam logic [AW-1:0]   LATCH_AD = '1;

  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_lvl);

  p_busy_nack_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && $past(phase) == PH_DEV) |-> !sda_oe);

  p_prot_drop_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (wr_addr[AW-1:PAGE_W] != PROT_PG));

  p_ctrl_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && wr_addr[AW-1:PAGE_W] == CTRL_PG) |-> wel);

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && wr_addr == LATCH_AD) |=> $stable(wel));

  p_page_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> (ptr[AW-1:PAGE_W] == $past(ptr[AW-1:PAGE_W])));

  p_reset_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sda_oe && !wel && phase == PH_IDLE));
endmodule

bind twowire_reg_slave tws_checker #(.AW(AW), .PAGE_W(PAGE_W), .PROT_PAGE(PROT_PAGE)) chk_i (
  .clk(clk), .rst(rst), .sda_oe(sda_oe_o), .scl_lvl(scl_lvl), .busy(busy),
  .phase(phase), .wr_req(wr_req), .wr_addr(wr_addr), .ptr(ptr), .wel(wel),
  .mem_we(mem_we)
);

// File: tb/twowire_reg_slave_tb_top.sv
`timescale 1ns/1ps
module twowire_reg_slave_tb_top;
  localparam logic [6:0] DEV = 7'h50;
  localparam int H = 20;
  localparam int BUSY = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic bus_sda;
  assign bus_sda = m_sda & ~sda_oe;

  twowire_reg_slave #(.DEV_ADDR(DEV), .BUSY_CYC(BUSY)) dut_i (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe_o(sda_oe)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int viol = 0;
  bit done = 0;
  logic [7:0] model [256];
  bit wel_m = 0;
  int ptr_m = 0;
  logic prev_scl = 1'b1;
  logic prev_oe = 1'b0;

  // R10 monitor: compared every clock
  always @(negedge clk) begin
    if (!rst && m_scl && prev_scl && (sda_oe !== prev_oe)) viol++;
    prev_scl = m_scl;
    prev_oe  = sda_oe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_write(input int a, input logic [7:0] v);
    if (a == 255) begin
      wel_m = v[1];
      model[255] = wel_m ? 8'h02 : 8'h00;
      return 0;
    end
    if ((a >> 6) == 2) return 0;
    if ((a >> 6) == 3) begin
      if (wel_m) model[a] = v;
      return 0;
    end
    model[a] = v;
    return 1;
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(H/2);
    m_scl = 1'b1; wt(H);
    m_sda = 1'b0; wt(H);
    m_scl = 1'b0; wt(H/2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(H/2);
    m_scl = 1'b1; wt(H);
    m_sda = 1'b1; wt(H);
  endtask

  task automatic tx(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(H/2);
      m_scl = 1'b1; wt(H);
      m_scl = 1'b0; wt(H/2);
    end
    m_sda = 1'b1; wt(H/2);
    ack = !bus_sda;
    m_scl = 1'b1; wt(H);
    m_scl = 1'b0; wt(H/2);
  endtask

  task automatic rx(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H/2);
      b[i] = bus_sda;
      m_scl = 1'b1; wt(H);
      m_scl = 1'b0; wt(H/2);
    end
    m_sda = give_ack ? 1'b0 : 1'b1; wt(H/2);
    m_scl = 1'b1; wt(H);
    m_scl = 1'b0; wt(H/2);
    m_sda = 1'b1;
  endtask

  task automatic wr_seq(input int a, input logic [7:0] d[$], input string tag, output bit nv);
    bit ack;
    int p;
    nv = 0;
    bus_start();
    tx({DEV, 1'b0}, ack); chk({tag, " device ack"}, ack, 1);
    tx(8'(a), ack);       chk({tag, " word address ack"}, ack, 1);
    p = a;
    foreach (d[k]) begin
      tx(d[k], ack); chk({tag, " data ack"}, ack, 1);
      if (m_write(p, d[k])) nv = 1;
      p = (p & 8'hC0) | ((p + 1) & 8'h3F);
    end
    bus_stop();
    ptr_m = p;
  endtask

  task automatic rd_n(input int n, input string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      rx(k != n - 1, b);
      chk({tag, " read data"}, b, model[ptr_m]);
      ptr_m = (ptr_m + 1) & 255;
    end
  endtask

  task automatic rd_rand(input int a, input int n, input string tag);
    bit ack;
    bus_start();
    tx({DEV, 1'b0}, ack); chk({tag, " dummy write ack"}, ack, 1);
    tx(8'(a), ack);       chk({tag, " word address ack"}, ack, 1);
    bus_start();
    tx({DEV, 1'b1}, ack); chk({tag, " read address ack"}, ack, 1);
    ptr_m = a;
    rd_n(n, tag);
    bus_stop();
  endtask

  task automatic rd_cur(input int n, input string tag);
    bit ack;
    bus_start();
    tx({DEV, 1'b1}, ack); chk({tag, " read address ack"}, ack, 1);
    rd_n(n, tag);
    bus_stop();
  endtask

  task automatic poll(output bit ack);
    bus_start();
    tx({DEV, 1'b0}, ack);
    bus_stop();
  endtask

  task automatic wait_ready(input string tag);
    bit ack = 0;
    for (int t = 0; t < 30 && !ack; t++) poll(ack);
    chk({tag, " acknowledge returns after busy"}, ack, 1);
  endtask

  initial begin
    logic [7:0] q[$];
    logic [7:0] b;
    bit nv, ack;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    wt(10);
    rst = 1'b0;
    wt(5);
    chk("R11 sda released after reset", sda_oe, 0);

    // R6/R11: latch reads back clear
    rd_rand(8'hFF, 1, "R6 R11 latch clear at start");

    // R2 byte write, R8 busy polling
    q = {8'hA5};
    wr_seq(8'h10, q, "R2 byte write", nv);
    chk("R8 array write starts busy", nv, 1);
    poll(ack);
    chk("R8 address not acknowledged while busy", ack, 0);
    bus_start();
    tx({DEV, 1'b1}, ack);
    bus_stop();
    chk("R8 read address not acknowledged while busy", ack, 0);
    wait_ready("R8");
    rd_rand(8'h10, 1, "R2 R5 random read");

    // R3 page write with wrap, R4 current-address read
    q = {8'h11, 8'h22, 8'h33, 8'h44};
    wr_seq(8'h3E, q, "R3 page write", nv);
    wait_ready("R8 page");
    rd_rand(8'h3E, 2, "R3 R5 page tail");
    chk("R3 byte 0x40 untouched", model[8'h40], 0);
    rd_cur(1, "R4 current address continues to 0x40");
    rd_rand(8'h00, 2, "R3 wrapped bytes at page start");
    rd_cur(2, "R4 current address follows random read");

    // R7 protected page
    q = {8'h55};
    wr_seq(8'h90, q, "R7 protected write", nv);
    poll(ack);
    chk("R7 no busy after protected write", ack, 1);
    rd_rand(8'h90, 1, "R7 protected byte unchanged");

    // R6 control page gated by latch
    q = {8'h33};
    wr_seq(8'hC5, q, "R6 control write latch clear", nv);
    poll(ack);
    chk("R6 no busy after control write", ack, 1);
    rd_rand(8'hC5, 1, "R6 dropped while latch clear");
    q = {8'h02};
    wr_seq(8'hFF, q, "R6 set latch", nv);
    rd_rand(8'hFF, 1, "R6 latch reads set");
    q = {8'h33, 8'h44};
    wr_seq(8'hC5, q, "R6 control write latch set", nv);
    poll(ack);
    chk("R6 no busy after accepted control write", ack, 1);
    rd_rand(8'hC5, 2, "R6 control stored");
    q = {8'h00};
    wr_seq(8'hFF, q, "R6 clear latch", nv);
    rd_rand(8'hFF, 1, "R6 latch reads clear");

    // R9 mismatched device address, R1 recovery by next start
    bus_start();
    tx({7'h52, 1'b0}, ack); chk("R9 wrong address no ack", ack, 0);
    tx(8'h10, ack);         chk("R9 following byte ignored", ack, 0);
    tx(8'hEE, ack);         chk("R9 data ignored", ack, 0);
    bus_stop();
    rd_rand(8'h10, 1, "R9 R1 memory unchanged, slave answers after start");
    bus_start();
    tx({7'h51, 1'b1}, ack); chk("R9 wrong read address no ack", ack, 0);
    rx(1'b0, b);
    chk("R9 line stays released after rejected read", b, 8'hFF);
    bus_stop();

    // R1 start aborts a write in progress
    bus_start();
    tx({DEV, 1'b0}, ack);
    bus_start();
    tx({DEV, 1'b1}, ack); chk("R1 repeated start restarts at device address", ack, 1);
    rx(1'b0, b);
    chk("R1 R4 read from pointer after aborted write", b, model[ptr_m]);
    ptr_m = (ptr_m + 1) & 255;
    bus_stop();

    wt(20);
    chk("R10 drive stable while SCL high (violations)", viol, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule